// File: doc/BRIEF.md
# Two-Way Mixed-Width Integer Dot-Product Accumulator

This unit multiplies the two 16-bit halves of a 32-bit word A by two 8-bit values drawn from a 32-bit word B, then adds both products to a 32-bit addend C. The two bytes come from one half of B, and a select input chooses which half. A has its own control for unsigned or signed interpretation, and so do the B bytes. The result is the 32-bit sum modulo 2^32.

The unit is a two-stage pipeline with no backpressure. It accepts a new operation in every cycle in which `in_vld` is high. The result appears on `out_res` with `out_vld` high exactly two cycles later. The control inputs are sampled together with the operands.

Top module: `dot2_mac`

## Requirements
- R1: A is split into a low lane (bits 15:0) and a high lane (bits 31:16). When `a_uns` is 0, both lanes are treated as signed 16-bit values. When it is 1, both are treated as unsigned.
- R2: When `b_hi` is 0, the bytes are B bits 7:0 (low byte) and 15:8 (high byte). When `b_hi` is 1, they are B bits 23:16 (low byte) and 31:24 (high byte). B bytes outside the selected half have no effect on the result.
- R3: When `b_uns` is 0, each selected byte is treated as a signed 8-bit value. When it is 1, each is treated as unsigned. This control is independent of `a_uns`.
- R4: The result is C + alo*blo + ahi*bhi, taken modulo 2^32. Overflow wraps silently, with no saturation and no flag.
- R5: `out_vld` is high in the cycle exactly two rising edges after `in_vld` was high. In that same cycle, `out_res` holds the result for those inputs.
- R6: Operations presented on consecutive cycles each produce their own result, in order, on consecutive cycles.
- R7: A synchronous active-high `rst` clears `out_vld` and the internal valid stage. `out_vld` stays low until two cycles after the first accepted input following reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input operation valid |
| a_uns | input | 1 | A lanes unsigned when 1 |
| b_uns | input | 1 | B bytes unsigned when 1 |
| b_hi | input | 1 | Select upper half of B when 1 |
| op_a | input | 32 | Operand with two 16-bit lanes |
| op_b | input | 32 | Operand supplying two bytes |
| op_c | input | 32 | Addend |
| out_vld | output | 1 | Result valid |
| out_res | output | 32 | Result |

## Verification
The bench runs every combination of the two signedness controls with both half selects. It also drives the extreme lanes 0x8000 against 0x80 and 0xFFFF against 0xFF. In those cases, a design that extends the wrong way or ignores one control gives products that differ in sign or magnitude. Junk is placed in the unselected half of B, so a wrong half or a swapped byte pairing shows up as a wrong sum. Addends near 2^31 and 2^32 make the sum wrap, which catches a saturating or miswidthed adder. Back-to-back and gapped valid patterns catch a pipeline that is one stage off or drops an operation.

// File: rtl/dot2_mac.sv
module dot2_mac #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic         a_uns,
  input  logic         b_uns,
  input  logic         b_hi,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  output logic         out_vld,
  output logic [W-1:0] out_res
);
  localparam int HW = W / 2;
  localparam int BW = W / 4;

  logic [HW-1:0] a_lo, a_hi;
  logic [BW-1:0] b_lo, b_hi_byte;
  logic [W-1:0]  ax_lo, ax_hi, bx_lo, bx_hi;
  logic [W-1:0]  p_lo_q, p_hi_q, c_q;
  logic          v1_q, v2_q;
  logic [W-1:0]  res_q;

  assign a_lo      = op_a[HW-1:0];
  assign a_hi      = op_a[W-1:HW];
  assign b_lo      = b_hi ? op_b[HW+BW-1:HW] : op_b[BW-1:0];
  assign b_hi_byte = b_hi ? op_b[W-1:HW+BW]  : op_b[2*BW-1:BW];

  assign ax_lo = {{(W-HW){a_lo[HW-1] & ~a_uns}}, a_lo};
  assign ax_hi = {{(W-HW){a_hi[HW-1] & ~a_uns}}, a_hi};
  assign bx_lo = {{(W-BW){b_lo[BW-1] & ~b_uns}}, b_lo};
  assign bx_hi = {{(W-BW){b_hi_byte[BW-1] & ~b_uns}}, b_hi_byte};

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= in_vld;
      v2_q <= v1_q;
    end
  end

  always_ff @(posedge clk) begin
    p_lo_q <= ax_lo * bx_lo;
    p_hi_q <= ax_hi * bx_hi;
    c_q    <= op_c;
    res_q  <= c_q + p_lo_q + p_hi_q;
  end

  assign out_vld = v2_q;
  assign out_res = res_q;
endmodule

// File: rtl/dot2_mac_chk.sv
module dot2_mac_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_vld,
  input logic        out_vld,
  input logic        v1_q,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic [31:0] op_c,
  input logic        a_uns,
  input logic        b_uns,
  input logic        b_hi,
  input logic [31:0] out_res
);
  function automatic logic [31:0] ref_f(input logic [31:0] a, b, c,
                                        input logic au, bu, bh);
    logic [15:0] l, h;
    logic [7:0]  x, y;
    logic [31:0] el, eh, ex, ey;
    l = a[15:0]; h = a[31:16];
    x = bh ? b[23:16] : b[7:0];
    y = bh ? b[31:24] : b[15:8];
    el = au ? {16'd0, l} : {{16{l[15]}}, l};
    eh = au ? {16'd0, h} : {{16{h[15]}}, h};
    ex = bu ? {24'd0, x} : {{24{x[7]}}, x};
    ey = bu ? {24'd0, y} : {{24{y[7]}}, y};
    return c + el * ex + eh * ey;
  endfunction

  p_valid_lat_r5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) == 1'b0 |-> v1_q == $past(in_vld));
  p_valid_out_r5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) == 1'b0 |=> out_vld == $past(in_vld, 2));
  p_result_r4: assert property (@(posedge clk) disable iff (rst)
    in_vld |-> ##2 out_res == $past(ref_f(op_a, op_b, op_c, a_uns, b_uns, b_hi), 2));
  p_reset_r7: assert property (@(posedge clk) rst |=> !out_vld && !v1_q);
endmodule

bind dot2_mac dot2_mac_chk u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .out_vld(out_vld), .v1_q(v1_q),
  .op_a(op_a), .op_b(op_b), .op_c(op_c), .a_uns(a_uns), .b_uns(b_uns),
  .b_hi(b_hi), .out_res(out_res)
);

// File: tb/tb_dot2_mac.sv
module tb_dot2_mac;
  logic clk = 0, rst = 1, in_vld = 0, a_uns = 0, b_uns = 0, b_hi = 0;
  logic [31:0] op_a = 0, op_b = 0, op_c = 0;
  logic out_vld;
  logic [31:0] out_res;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  dot2_mac dut (.*);

  function automatic logic [31:0] expect_f(input logic [31:0] a, b, c,
                                           input logic au, bu, bh);
    int signed sl, sh, sx, sy;
    longint p;
    sl = au ? int'(a[15:0]) : int'($signed(a[15:0]));
    sh = au ? int'(a[31:16]) : int'($signed(a[31:16]));
    sx = bu ? int'(bh ? b[23:16] : b[7:0])  : int'($signed(bh ? b[23:16] : b[7:0]));
    sy = bu ? int'(bh ? b[31:24] : b[15:8]) : int'($signed(bh ? b[31:24] : b[15:8]));
    p = longint'(sl) * sx + longint'(sh) * sy + longint'(c);
    return p[31:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] q_exp [$];
  logic [31:0] e;

  always @(negedge clk) begin
    if (!rst && out_vld) begin
      if (q_exp.size() == 0) chk("R5 spurious out_vld", 32'd1, 32'd0);
      else begin
        e = q_exp.pop_front();
        chk("R4 R6 result", out_res, e);
      end
    end
  end

  task automatic issue(input logic [31:0] a, b, c, input logic au, bu, bh);
    @(negedge clk);
    op_a = a; op_b = b; op_c = c; a_uns = au; b_uns = bu; b_hi = bh; in_vld = 1;
    q_exp.push_back(expect_f(a, b, c, au, bu, bh));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 0; op_a = $urandom; op_b = $urandom;
    end
  endtask

  initial begin
    fork
      begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R7 reset out_vld", {31'd0, out_vld}, 32'd0);
        rst = 0;
        idle(2);
        chk("R7 idle after reset", {31'd0, out_vld}, 32'd0);
        // R5: single op latency
        issue(32'h0003_0002, 32'h0000_0504, 32'd10, 0, 0, 0);
        idle(1);
        chk("R5 not yet valid", {31'd0, out_vld}, 32'd0);
        @(negedge clk);
        chk("R5 valid at +2", {31'd0, out_vld}, 32'd1);
        chk("R4 value 10+8+15", out_res, 32'd33);
        idle(2);
        // R1 R2 R3: all controls, corners, junk in unused half
        for (int m = 0; m < 8; m++) begin
          issue(32'h8000_8000, 32'h8080_8080, 32'd0, m[0], m[1], m[2]);
          issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd7, m[0], m[1], m[2]);
          issue(32'h8000_FFFF, m[2] ? 32'h80FF_1234 : 32'h5678_80FF, 32'hFFFF_FFF0, m[0], m[1], m[2]);
          issue(32'h7FFF_0001, m[2] ? 32'h7F01_A5C3 : 32'h3C5A_7F01, 32'h7FFF_FFFF, m[0], m[1], m[2]);
        end
        idle(3);
        // R2 direct: unselected half ignored
        issue(32'h0001_0001, 32'hDEAD_0102, 32'd0, 1, 1, 0);
        idle(2);
        chk("R2 low half", out_res, 32'd3);
        issue(32'h0001_0001, 32'h0304_BEEF, 32'd0, 1, 1, 1);
        idle(2);
        chk("R2 high half", out_res, 32'd7);
        // R4 wraparound
        issue(32'h0000_FFFF, 32'h0000_00FF, 32'hFFFF_0000, 1, 1, 0);
        idle(2);
        chk("R4 wrap", out_res, 32'hFFFF_0000 + 32'd16711425);
        // R6 random back-to-back with gaps
        for (int i = 0; i < 400; i++) begin
          if ($urandom % 4 == 0) idle(1);
          issue($urandom, $urandom, $urandom, 1'($urandom), 1'($urandom), 1'($urandom));
        end
        idle(4);
        chk("R6 all drained", q_exp.size(), 32'd0);
        // R7 reset mid-flight
        issue(32'h1, 32'h1, 32'h1, 1, 1, 0);
        @(negedge clk);
        in_vld = 0; rst = 1;
        q_exp.delete();
        @(negedge clk);
        rst = 0;
        chk("R7 flushed", {31'd0, out_vld}, 32'd0);
        @(negedge clk);
        chk("R7 flushed later", {31'd0, out_vld}, 32'd0);
      end
      begin
        repeat (20000) @(posedge clk);
        chk("watchdog", 32'd1, 32'd0);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule